// File: doc/BRIEF.md
# Multi-slot response data buffer

This block holds read data for outstanding requests until each response is complete. Its storage is 48 dwords, cut into three slots of 16 dwords. Each slot belongs to one outstanding read or nonposted request. A requester allocates a slot by giving it an expected dword count and a response header. Data then arrives on two independent write ports, one from the bus interface and one from an internal register master. Each write names a slot and a dword offset, so writes for different slots may interleave in any order.

A slot becomes ready once it has received as many dwords as it expects. A nonposted write allocates with a count of zero. It therefore occupies a slot but is ready at once. The response stage always takes the lowest-numbered ready slot. It streams that slot's data in offset order, with the stored header on every beat, and frees the slot when the final beat is accepted. The buffer is not a FIFO: slots fill and complete independently of their allocation order.

Top module: `resp_slot_buf`

## Requirements
- R1: After reset all three slots are free, so `alloc_ready`=1 and `alloc_slot`=0. In the same state `rsp_valid`=0 and `wr_err`=0.
- R2: An accepted allocation (`alloc_valid` with `alloc_ready`) takes the lowest-numbered free slot, and `alloc_slot` reports which one. Slot indices are 0, 1 and 2.
- R3: While all three slots are in use, `alloc_ready` is 0 and an allocation request has no effect.
- R4: An allocation with count 0 makes the slot ready at once. Its response is one beat with `rsp_empty`=1, `rsp_last`=1 and `rsp_data`=0.
- R5: A slot with count N (1 to 16) becomes ready only after N valid dword writes have reached it. Those writes may arrive at any offsets, in any order, and interleaved with writes to other slots.
- R6: Both write ports store their dword at offset `off` of slot `slot`. A write is valid when the slot is filling and `off` is less than the slot's count. The bus port wins if both ports hit the same location in one cycle.
- R7: A write to slot index 3, to a slot that is not filling, or at an offset at or beyond the slot's count is dropped. Such a write raises `wr_err` for exactly the next cycle.
- R8: When several slots are ready, the response stage serves the lowest-numbered ready slot first. Each response runs to completion before the next slot is chosen.
- R9: Response beat k carries the dword at offset k, together with the slot's header and index. `rsp_last` marks beat N-1. While `rsp_ready` is 0, the beat is held unchanged.
- R10: A slot is freed on the clock edge at which its last beat is accepted, and it can be allocated again from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_count | input | 5 | Expected dwords, 0 to 16 |
| alloc_hdr | input | 32 | Response header stored with the slot |
| alloc_ready | output | 1 | At least one slot is free |
| alloc_slot | output | 2 | Slot an allocation would take |
| bw_valid | input | 1 | Bus-side data write |
| bw_slot | input | 2 | Bus-side target slot |
| bw_off | input | 4 | Bus-side dword offset |
| bw_data | input | 32 | Bus-side dword |
| cw_valid | input | 1 | Register-master data write |
| cw_slot | input | 2 | Register-master target slot |
| cw_off | input | 4 | Register-master dword offset |
| cw_data | input | 32 | Register-master dword |
| wr_err | output | 1 | A write was dropped in the previous cycle |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Response beat accepted |
| rsp_slot | output | 2 | Slot being drained |
| rsp_hdr | output | 32 | Header of that slot |
| rsp_data | output | 32 | Dword of this beat |
| rsp_empty | output | 1 | Header-only response (count 0) |
| rsp_last | output | 1 | Final beat of the response |

## Verification
Suppose a slot's received count or state is corrupted. The response either starts a cycle early, when `rsp_valid` rises before the last dword, or it never starts, and a free slot stays hidden from `alloc_ready`. Either shows up within a cycle of the missing or extra write. A wrong address computation shows up as wrong `rsp_data` on the matching beat. A broken priority scan shows up as the wrong `rsp_slot` or `alloc_slot` in the first cycle of a choice. The reference model compares every output on every cycle, so each fault is reported in the cycle it first becomes visible.

// File: rtl/rsb_pkg.sv
// Shared types for the response slot buffer.
// Assumes: a slot is in exactly one of three life-cycle states.
package rsb_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_FILL  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;
endpackage

// File: rtl/rsb_slot_ctrl.sv
// Per-slot bookkeeping: holds the expected count, the header and the
// received count, and steps FREE -> FILL -> READY -> FREE.
// Assumes: alloc_hit only arrives when the slot is FREE; inc only counts
// writes the top has already validated against this slot.
module rsb_slot_ctrl
    import rsb_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int HDR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_hit,
    input  logic [CNT_W-1:0] alloc_count,
    input  logic [HDR_W-1:0] alloc_hdr,
    input  logic [1:0]       inc,
    input  logic             done,
    output slot_state_e      state,
    output logic [CNT_W-1:0] count,
    output logic [HDR_W-1:0] hdr
);
    logic [CNT_W-1:0] recv;
    logic [CNT_W:0]   recv_sum;

    // Received total including this cycle's accepted writes.
    always_comb recv_sum = {1'b0, recv} + (CNT_W+1)'(inc);

    // Slot life cycle and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SLOT_FREE;
            recv  <= '0;
            count <= '0;
            hdr   <= '0;
        end else if (done) begin
            state <= SLOT_FREE;
        end else if (alloc_hit) begin
            count <= alloc_count;
            hdr   <= alloc_hdr;
            recv  <= '0;
            state <= (alloc_count == '0) ? SLOT_READY : SLOT_FILL;
        end else if (state == SLOT_FILL && inc != 2'd0) begin
            recv <= recv_sum[CNT_W-1:0];
            if (recv_sum >= {1'b0, count}) state <= SLOT_READY;
        end
    end

    // A filling slot has always received fewer dwords than it expects.
    assert_recv_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state == SLOT_FILL |-> recv < count);

    // A zero-count allocation is ready on the next cycle.
    assert_zero_count_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_hit && !done && alloc_count == '0) |=> state == SLOT_READY);
endmodule

// File: rtl/rsb_store.sv
// Dword storage for all slots, two write ports and one combinational read.
// Assumes: enables are asserted only for validated in-range locations;
// port A is written last so it wins a same-address collision.
module rsb_store #(
    parameter int NUM_SLOTS = 3,
    parameter int SLOT_DW   = 16,
    parameter int DW_W      = 32,
    parameter int SLOT_W    = 2,
    parameter int OFF_W     = 4
) (
    input  logic              clk,
    input  logic              a_en,
    input  logic [SLOT_W-1:0] a_slot,
    input  logic [OFF_W-1:0]  a_off,
    input  logic [DW_W-1:0]   a_data,
    input  logic              b_en,
    input  logic [SLOT_W-1:0] b_slot,
    input  logic [OFF_W-1:0]  b_off,
    input  logic [DW_W-1:0]   b_data,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DW_W-1:0]   rd_data
);
    localparam int TOTAL  = NUM_SLOTS * SLOT_DW;
    localparam int ADDR_W = $clog2(TOTAL);

    logic [DW_W-1:0]   mem [TOTAL];
    logic [ADDR_W-1:0] a_addr, b_addr, r_addr;

    // Flat address of a (slot, offset) pair.
    function automatic logic [ADDR_W-1:0] flat(input logic [SLOT_W-1:0] s,
                                               input logic [OFF_W-1:0] o);
        return ADDR_W'(s) * ADDR_W'(SLOT_DW) + ADDR_W'(o);
    endfunction

    // Address computation for both writers and the reader.
    always_comb begin
        a_addr = flat(a_slot, a_off);
        b_addr = flat(b_slot, b_off);
        r_addr = flat(rd_slot, rd_off);
    end

    // Storage writes; port A last so it takes precedence.
    always_ff @(posedge clk) begin
        if (b_en) mem[b_addr] <= b_data;
        if (a_en) mem[a_addr] <= a_data;
    end

    // Read port used by the response stage.
    always_comb rd_data = mem[r_addr];
endmodule

// File: rtl/rsb_drain.sv
// Response stage: chooses the lowest ready slot, streams its dwords in
// offset order with its header, and pulses done on the final accepted beat.
// Assumes: a slot stays READY until done is seen for it.
module rsb_drain #(
    parameter int NUM_SLOTS = 3,
    parameter int SLOT_W    = 2,
    parameter int OFF_W     = 4,
    parameter int CNT_W     = 5,
    parameter int HDR_W     = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SLOTS-1:0]            ready_v,
    input  logic [NUM_SLOTS-1:0][CNT_W-1:0] cnt_v,
    input  logic [NUM_SLOTS-1:0][HDR_W-1:0] hdr_v,
    input  logic                            rsp_ready,
    output logic                            rsp_valid,
    output logic [SLOT_W-1:0]               rsp_slot,
    output logic [HDR_W-1:0]                rsp_hdr,
    output logic                            rsp_empty,
    output logic                            rsp_last,
    output logic [OFF_W-1:0]                rd_off,
    output logic [NUM_SLOTS-1:0]            done
);
    logic              active;
    logic [SLOT_W-1:0] cur;
    logic [OFF_W-1:0]  idx;
    logic [SLOT_W-1:0] pick;
    logic [CNT_W-1:0]  cur_cnt;

    // Lowest-numbered ready slot.
    always_comb begin
        pick = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--)
            if (ready_v[i]) pick = SLOT_W'(i);
    end

    // Beat decode for the slot being drained.
    always_comb begin
        cur_cnt   = cnt_v[cur];
        rsp_empty = (cur_cnt == '0);
        rsp_last  = rsp_empty || (CNT_W'(idx) == cur_cnt - CNT_W'(1));
        rsp_valid = active;
        rsp_slot  = cur;
        rsp_hdr   = hdr_v[cur];
        rd_off    = idx;
    end

    // Release pulse for the slot whose last beat is accepted.
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++)
            done[i] = active && rsp_ready && rsp_last && (cur == SLOT_W'(i));
    end

    // Selection and beat sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cur    <= '0;
            idx    <= '0;
        end else if (active) begin
            if (rsp_ready) begin
                if (rsp_last) active <= 1'b0;
                else          idx    <= idx + OFF_W'(1);
            end
        end else if (|ready_v) begin
            active <= 1'b1;
            cur    <= pick;
            idx    <= '0;
        end
    end

    // A stalled beat is held unchanged.
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_slot) && $stable(rd_off)));

    // Only a ready slot is ever served.
    assert_serve_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ready_v[rsp_slot]);

    // At most one slot released per cycle.
    assert_single_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));
endmodule

// File: rtl/resp_slot_buf.sv
// Top of the response slot buffer: allocation of the lowest free slot,
// validation of both write ports, per-slot control, storage and drain.
// Assumes: the bus-side port has priority on a same-location collision.
module resp_slot_buf
    import rsb_pkg::*;
#(
    parameter int NUM_SLOTS = 3,
    parameter int SLOT_DW   = 16,
    parameter int DW_W      = 32,
    parameter int HDR_W     = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS + 1),
    localparam int OFF_W    = $clog2(SLOT_DW),
    localparam int CNT_W    = $clog2(SLOT_DW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [CNT_W-1:0]  alloc_count,
    input  logic [HDR_W-1:0]  alloc_hdr,
    output logic              alloc_ready,
    output logic [SLOT_W-1:0] alloc_slot,
    input  logic              bw_valid,
    input  logic [SLOT_W-1:0] bw_slot,
    input  logic [OFF_W-1:0]  bw_off,
    input  logic [DW_W-1:0]   bw_data,
    input  logic              cw_valid,
    input  logic [SLOT_W-1:0] cw_slot,
    input  logic [OFF_W-1:0]  cw_off,
    input  logic [DW_W-1:0]   cw_data,
    output logic              wr_err,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [SLOT_W-1:0] rsp_slot,
    output logic [HDR_W-1:0]  rsp_hdr,
    output logic [DW_W-1:0]   rsp_data,
    output logic              rsp_empty,
    output logic              rsp_last
);
    slot_state_e                     st [NUM_SLOTS];
    logic [NUM_SLOTS-1:0][CNT_W-1:0] cnt_v;
    logic [NUM_SLOTS-1:0][HDR_W-1:0] hdr_v;
    logic [NUM_SLOTS-1:0]            ready_v;
    logic [NUM_SLOTS-1:0]            done_v;
    logic [1:0]                      inc_v [NUM_SLOTS];
    logic                            bw_in, cw_in, bw_ok, cw_ok;
    logic [SLOT_W-1:0]               bw_idx, cw_idx;
    logic [OFF_W-1:0]                rd_off;
    logic [DW_W-1:0]                 rd_data;

    // Lowest free slot for allocation.
    always_comb begin
        alloc_ready = 1'b0;
        alloc_slot  = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--)
            if (st[i] == SLOT_FREE) begin
                alloc_ready = 1'b1;
                alloc_slot  = SLOT_W'(i);
            end
    end

    // Write validation: slot in range, filling, offset under its count.
    always_comb begin
        bw_in  = {1'b0, bw_slot} < (SLOT_W+1)'(NUM_SLOTS);
        cw_in  = {1'b0, cw_slot} < (SLOT_W+1)'(NUM_SLOTS);
        bw_idx = bw_in ? bw_slot : '0;
        cw_idx = cw_in ? cw_slot : '0;
        bw_ok  = bw_valid && bw_in && st[bw_idx] == SLOT_FILL
                 && CNT_W'(bw_off) < cnt_v[bw_idx];
        cw_ok  = cw_valid && cw_in && st[cw_idx] == SLOT_FILL
                 && CNT_W'(cw_off) < cnt_v[cw_idx];
    end

    // Registered flag for any dropped write.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_err <= 1'b0;
        else        wr_err <= (bw_valid && !bw_ok) || (cw_valid && !cw_ok);
    end

    // Per-slot control instances.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic alloc_hit;
        always_comb begin
            alloc_hit   = alloc_valid && alloc_ready && alloc_slot == SLOT_W'(g);
            inc_v[g]    = {1'b0, bw_ok && bw_idx == SLOT_W'(g)}
                        + {1'b0, cw_ok && cw_idx == SLOT_W'(g)};
            ready_v[g]  = st[g] == SLOT_READY;
        end
        rsb_slot_ctrl #(.CNT_W(CNT_W), .HDR_W(HDR_W)) u_ctrl (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_hit  (alloc_hit),
            .alloc_count(alloc_count),
            .alloc_hdr  (alloc_hdr),
            .inc        (inc_v[g]),
            .done       (done_v[g]),
            .state      (st[g]),
            .count      (cnt_v[g]),
            .hdr        (hdr_v[g])
        );
    end

    rsb_store #(
        .NUM_SLOTS(NUM_SLOTS), .SLOT_DW(SLOT_DW), .DW_W(DW_W),
        .SLOT_W(SLOT_W), .OFF_W(OFF_W)
    ) u_store (
        .clk    (clk),
        .a_en   (bw_ok),
        .a_slot (bw_idx),
        .a_off  (bw_off),
        .a_data (bw_data),
        .b_en   (cw_ok),
        .b_slot (cw_idx),
        .b_off  (cw_off),
        .b_data (cw_data),
        .rd_slot(rsp_slot),
        .rd_off (rd_off),
        .rd_data(rd_data)
    );

    rsb_drain #(
        .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .OFF_W(OFF_W),
        .CNT_W(CNT_W), .HDR_W(HDR_W)
    ) u_drain (
        .clk      (clk),
        .rst_n    (rst_n),
        .ready_v  (ready_v),
        .cnt_v    (cnt_v),
        .hdr_v    (hdr_v),
        .rsp_ready(rsp_ready),
        .rsp_valid(rsp_valid),
        .rsp_slot (rsp_slot),
        .rsp_hdr  (rsp_hdr),
        .rsp_empty(rsp_empty),
        .rsp_last (rsp_last),
        .rd_off   (rd_off),
        .done     (done_v)
    );

    // Empty responses carry zero data.
    always_comb rsp_data = rsp_empty ? '0 : rd_data;

    // An out-of-range slot index always raises the error flag.
    assert_bad_slot_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_valid && !bw_in) |=> wr_err);

    // A refused allocation leaves the slot set fully occupied.
    assert_refuse_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !alloc_ready && done_v == '0) |=> !alloc_ready);
endmodule

// File: tb/sim_resp_slot_buf.sv
module sim_resp_slot_buf;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 3;
    localparam int SD = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [4:0]  alloc_count = '0;
    logic [31:0] alloc_hdr = '0;
    logic        alloc_ready;
    logic [1:0]  alloc_slot;
    logic        bw_valid = 1'b0, cw_valid = 1'b0;
    logic [1:0]  bw_slot = '0, cw_slot = '0;
    logic [3:0]  bw_off = '0, cw_off = '0;
    logic [31:0] bw_data = '0, cw_data = '0;
    logic        wr_err, rsp_valid, rsp_empty, rsp_last;
    logic        rsp_ready = 1'b0;
    logic [1:0]  rsp_slot;
    logic [31:0] rsp_hdr, rsp_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    int          m_st [NS];     // 0 free, 1 filling, 2 ready
    int          m_cnt [NS];
    int          m_rcv [NS];
    logic [31:0] m_hdr [NS];
    logic [31:0] m_mem [NS*SD];
    bit          m_wr [NS][SD];
    bit          m_act;
    int          m_cur, m_idx;
    bit          m_err;

    resp_slot_buf u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_count(alloc_count), .alloc_hdr(alloc_hdr),
        .alloc_ready(alloc_ready), .alloc_slot(alloc_slot),
        .bw_valid(bw_valid), .bw_slot(bw_slot), .bw_off(bw_off), .bw_data(bw_data),
        .cw_valid(cw_valid), .cw_slot(cw_slot), .cw_off(cw_off), .cw_data(cw_data),
        .wr_err(wr_err), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_slot(rsp_slot), .rsp_hdr(rsp_hdr), .rsp_data(rsp_data),
        .rsp_empty(rsp_empty), .rsp_last(rsp_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int low_free();
        for (int i = 0; i < NS; i++) if (m_st[i] == 0) return i;
        return -1;
    endfunction

    function automatic bit wr_ok(bit v, int s, int o);
        return v && s < NS && m_st[s] == 1 && o < m_cnt[s];
    endfunction

    // compare all outputs against the model
    task automatic compare();
        int lf;
        lf = low_free();
        chk("R3", "alloc_ready", 64'(alloc_ready), 64'(lf >= 0));
        if (lf >= 0) chk("R2", "alloc_slot", 64'(alloc_slot), 64'(lf));
        chk("R7", "wr_err", 64'(wr_err), 64'(m_err));
        chk("R5", "rsp_valid", 64'(rsp_valid), 64'(m_act));
        if (m_act) begin
            chk("R8", "rsp_slot", 64'(rsp_slot), 64'(m_cur));
            chk("R9", "rsp_hdr", 64'(rsp_hdr), 64'(m_hdr[m_cur]));
            chk("R4", "rsp_empty", 64'(rsp_empty), 64'(m_cnt[m_cur] == 0));
            chk("R9", "rsp_last", 64'(rsp_last),
                64'(m_cnt[m_cur] == 0 || m_idx == m_cnt[m_cur] - 1));
            if (m_cnt[m_cur] == 0) chk("R4", "rsp_data", 64'(rsp_data), 64'd0);
            else chk("R6", "rsp_data", 64'(rsp_data), 64'(m_mem[m_cur*SD + m_idx]));
        end
    endtask

    // choose one write; bad writes are generated on purpose
    task automatic gen_write(input int avoid_s, input int avoid_o,
                             output bit v, output int s, output int o);
        int tries;
        v = ($urandom_range(0, 99) < 70);
        s = 0; o = 0;
        if (!v) return;
        if ($urandom_range(0, 99) < 10) begin
            case ($urandom_range(0, 2))
                0: begin s = 3; o = $urandom_range(0, 15); end
                1: begin
                    s = low_free(); o = $urandom_range(0, 15);
                    if (s < 0) s = 3;
                end
                default: begin
                    s = 3; o = 0;
                    for (int i = 0; i < NS; i++)
                        if (m_st[i] == 1 && m_cnt[i] < SD) begin
                            s = i; o = $urandom_range(m_cnt[i], 15);
                        end
                end
            endcase
            return;
        end
        for (tries = 0; tries < 40; tries++) begin
            s = $urandom_range(0, NS - 1);
            if (m_st[s] == 1) begin
                o = $urandom_range(0, m_cnt[s] - 1);
                if (!m_wr[s][o] && !(s == avoid_s && o == avoid_o)) return;
            end
        end
        v = 0; s = 0; o = 0;
    endtask

    // advance the model by one clock edge using pre-edge state
    task automatic model_step();
        int lf, pick, ns;
        bit bv, cv, last;
        int pre_st [NS];
        for (int i = 0; i < NS; i++) pre_st[i] = m_st[i];
        lf = low_free();
        bv = wr_ok(bw_valid, int'(bw_slot), int'(bw_off));
        cv = wr_ok(cw_valid, int'(cw_slot), int'(cw_off));
        m_err = (bw_valid && !bv) || (cw_valid && !cv);
        if (cv) begin
            m_mem[int'(cw_slot)*SD + int'(cw_off)] = cw_data;
            m_wr[cw_slot][cw_off] = 1; m_rcv[cw_slot]++;
        end
        if (bv) begin
            m_mem[int'(bw_slot)*SD + int'(bw_off)] = bw_data;
            m_wr[bw_slot][bw_off] = 1; m_rcv[bw_slot]++;
        end
        for (int i = 0; i < NS; i++)
            if (pre_st[i] == 1 && m_rcv[i] >= m_cnt[i]) m_st[i] = 2;
        if (m_act) begin
            if (rsp_ready) begin
                last = (m_cnt[m_cur] == 0) || (m_idx == m_cnt[m_cur] - 1);
                if (last) begin m_st[m_cur] = 0; m_act = 0; end
                else m_idx++;
            end
        end else begin
            pick = -1;
            for (int i = NS - 1; i >= 0; i--) if (pre_st[i] == 2) pick = i;
            if (pick >= 0) begin m_act = 1; m_cur = pick; m_idx = 0; end
        end
        if (alloc_valid && lf >= 0) begin
            ns = lf;
            m_cnt[ns] = int'(alloc_count);
            m_hdr[ns] = alloc_hdr;
            m_rcv[ns] = 0;
            for (int k = 0; k < SD; k++) m_wr[ns][k] = 0;
            m_st[ns] = (alloc_count == 0) ? 2 : 1;
        end
    endtask

    initial begin
        int bs, bo, cs, co;
        bit bvv, cvv;
        for (int i = 0; i < NS; i++) begin
            m_st[i] = 0; m_cnt[i] = 0; m_rcv[i] = 0; m_hdr[i] = '0;
        end
        m_act = 0; m_cur = 0; m_idx = 0; m_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "alloc_ready", 64'(alloc_ready), 64'd1);
        chk("R1", "alloc_slot", 64'(alloc_slot), 64'd0);
        chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1", "wr_err", 64'(wr_err), 64'd0);
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if (cyc > 0) begin
                @(negedge clk);
                compare();
            end
            // R3/R8 pressure window: responses stalled, slots pile up
            if (cyc >= 1000 && cyc < 1300) rsp_ready = 1'b0;
            else rsp_ready = ($urandom_range(0, 99) < 75);
            alloc_valid = ($urandom_range(0, 99) < 30);
            case ($urandom_range(0, 4))
                0: alloc_count = 5'd0;               // R4 nonposted write
                1: alloc_count = 5'd16;              // full slot
                default: alloc_count = 5'($urandom_range(1, 16));
            endcase
            alloc_hdr = $urandom;
            gen_write(-1, -1, bvv, bs, bo);
            bw_valid = bvv; bw_slot = 2'(bs); bw_off = 4'(bo); bw_data = $urandom;
            gen_write(bvv ? bs : -1, bvv ? bo : -1, cvv, cs, co);
            cw_valid = cvv; cw_slot = 2'(cs); cw_off = 4'(co); cw_data = $urandom;
            model_step();
        end
        @(negedge clk);
        compare();
        // R10: drain everything; all slots free again
        alloc_valid = 0; bw_valid = 0; cw_valid = 0;
        for (int k = 0; k < 200; k++) begin
            rsp_ready = 1'b1;
            model_step();
            @(negedge clk);
            compare();
        end
        chk("R10", "all free after drain", 64'(alloc_ready && alloc_slot == 0), 64'(low_free() == 0));
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule